// File: doc/BRIEF.md
# Early-Acknowledge RAM Cycle Controller

This block is a bus slave that serves asynchronous read and write cycles from a 68000-style master to a simple RAM port. Each cycle runs on a fixed grid of clock counts. The grid starts at the clock edge where the controller first sees the address strobe low with the chip select active. That edge is count 0.

The controller lowers the transfer acknowledge at count 3, before the RAM has produced any data. This is safe because the master samples the acknowledge in one bus phase and latches the data several phases later. The acknowledge therefore only promises that data will be there when the master latches it. It is not a latch enable. The row strobe falls at count 4, and in a write the write enable falls with it. Read data is on the bus from count 6 and stays fixed until the master releases the address strobe, which it normally does at count 10.

A release at any earlier count drops the controller back to idle with every strobe high. A strobe that falls while the chip select is inactive is ignored until it has been released. The master's data bus is split into an input, an output and an output enable.

Top module: `early_ack_ram_ctrl`

## Requirements
- R1: While reset is held, and in idle after reset, `dtack_n`, `ram_ras_n`, `ram_we_n`, `ram_ube_n` and `ram_lbe_n` are 1 and `d_oe` is 0.
- R2: In a selected cycle, `dtack_n` is 1 at counts 0 to 2 and 0 from count 3 until the release. Count k is the state after the k-th rising edge that follows the edge where `as_n` was first seen low with `cs_n` low; that start edge is count 0.
- R3: `ram_ras_n` is 1 at counts 0 to 3 and 0 from count 4 until the release. From count 4, `ram_addr` equals the address presented at count 0.
- R4: In a read (`rw`=1), `d_oe` is 0 at counts 0 to 5 and 1 from count 6 until the release. While it is 1, `d_out` holds the RAM word at the cycle's address and does not change.
- R5: At the first rising edge where `as_n` is sampled 1 during a cycle, `dtack_n`, `ram_ras_n` and `ram_we_n` return to 1 and `d_oe` returns to 0.
- R6: In a write (`rw`=0), `ram_we_n` is 0 from count 4 until the release, together with `ram_ras_n`. From count 4, `ram_wdata` equals `d_in`, and `ram_ube_n`/`ram_lbe_n` equal `uds_n`/`lds_n`. An active-low enable of 0 writes the upper byte (bits 15:8) or the lower byte (bits 7:0).
- R7: If `cs_n` is 1 when `as_n` falls, no acknowledge, row strobe or write enable appears for the whole strobe period.
- R8: A release at any count from 0 to 9 leaves the controller idle one edge later with no strobe asserted. The next selected cycle follows the full R2 to R4 timing.
- R9: A cycle starts only on a falling edge of `as_n`. If `cs_n` goes low while `as_n` is already low, that strobe period is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| as_n | input | 1 | Address strobe from master, active low |
| cs_n | input | 1 | Chip select, active low |
| rw | input | 1 | 1 = read, 0 = write |
| uds_n | input | 1 | Upper byte strobe, active low |
| lds_n | input | 1 | Lower byte strobe, active low |
| addr | input | AW | Word address |
| d_in | input | DW | Write data from master |
| dtack_n | output | 1 | Transfer acknowledge, active low |
| d_out | output | DW | Read data to master |
| d_oe | output | 1 | Read data bus drive enable |
| ram_addr | output | AW | RAM address |
| ram_ras_n | output | 1 | RAM row strobe, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_ube_n | output | 1 | RAM upper byte enable, active low |
| ram_lbe_n | output | 1 | RAM lower byte enable, active low |
| ram_wdata | output | DW | RAM write data |
| ram_rdata | input | DW | RAM read data |

## Verification
The bench releases the strobe at every count from 0 to past 10. A controller whose abort path missed one state would leave the row strobe or the data drive stuck low into the idle gap. It raises the chip select at the strobe's falling edge, and separately lowers it only after the strobe is already down. A design that sampled the select at the wrong moment would acknowledge an unselected cycle or start one halfway through its grid. Single-byte writes followed by reads check that byte enables reach the RAM in the row-strobe slot. If the enables were off by one clock, the write would merge the wrong bytes. Reads check that the data bus is driven from exactly count 6. They also check that it stays unchanged through long holds: a design that tracked the raw RAM output would change data after the row strobe rose.

// File: rtl/early_ack_ram_ctrl.sv
module early_ack_ram_ctrl #(
  parameter int AW      = 8,
  parameter int DW      = 16,
  parameter int ACK_AT  = 3,
  parameter int RAS_AT  = 4,
  parameter int DATA_AT = 6,
  parameter int CW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          as_n,
  input  logic          cs_n,
  input  logic          rw,
  input  logic          uds_n,
  input  logic          lds_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] d_in,
  output logic          dtack_n,
  output logic [DW-1:0] d_out,
  output logic          d_oe,
  output logic [AW-1:0] ram_addr,
  output logic          ram_ras_n,
  output logic          ram_we_n,
  output logic          ram_ube_n,
  output logic          ram_lbe_n,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata
);

  localparam logic [CW-1:0] ACK_C  = CW'(ACK_AT);
  localparam logic [CW-1:0] RAS_C  = CW'(RAS_AT);
  localparam logic [CW-1:0] DATA_C = CW'(DATA_AT);
  localparam logic [CW-1:0] LAST_C = {CW{1'b1}};

  logic          busy, as_q, rd_q, ube_q, lbe_q;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q, rd_hold;
  logic          start, release_now;

  assign start       = !busy && as_q && !as_n && !cs_n;
  assign release_now = busy && as_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      as_q    <= 1'b1;
      rd_q    <= 1'b1;
      cnt     <= '0;
      addr_q  <= '0;
      wd_q    <= '0;
      rd_hold <= '0;
      ube_q   <= 1'b1;
      lbe_q   <= 1'b1;
    end else begin
      as_q <= as_n;
      if (start) begin
        busy   <= 1'b1;
        cnt    <= '0;
        rd_q   <= rw;
        addr_q <= addr;
        ube_q  <= 1'b1;
        lbe_q  <= 1'b1;
      end else if (release_now) begin
        busy  <= 1'b0;
        cnt   <= '0;
        ube_q <= 1'b1;
        lbe_q <= 1'b1;
      end else if (busy) begin
        if (cnt != LAST_C) cnt <= cnt + 1'b1;
        if (cnt == RAS_C - 1'b1) begin
          ube_q <= uds_n;
          lbe_q <= lds_n;
          if (!rd_q) wd_q <= d_in;
        end
        if (rd_q && cnt == DATA_C - 1'b1) rd_hold <= ram_rdata;
      end
    end
  end

  assign dtack_n   = !(busy && cnt >= ACK_C);
  assign ram_ras_n = !(busy && cnt >= RAS_C);
  assign ram_we_n  = !(busy && !rd_q && cnt >= RAS_C);
  assign d_oe      = busy && rd_q && cnt >= DATA_C;
  assign d_out     = rd_hold;
  assign ram_addr  = addr_q;
  assign ram_wdata = wd_q;
  assign ram_ube_n = ube_q;
  assign ram_lbe_n = lbe_q;

  a_r3_ras_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_ras_n |-> !dtack_n);

  a_r2_ack_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dtack_n) |-> !$past(as_n));

  a_r4_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (d_oe && $past(d_oe)) |-> $stable(d_out));

  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    release_now |=> (dtack_n && ram_ras_n && ram_we_n && !d_oe));

  a_r6_we_with_ras: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> !ram_ras_n);

  a_r7_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cs_n) |=> (dtack_n && ram_ras_n));

endmodule

// File: tb/early_ack_ram_ctrl_test.sv
module early_ack_ram_ctrl_test;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic as_n = 1, cs_n = 1, rw = 1, uds_n = 1, lds_n = 1;
  logic [7:0]  addr = 0;
  logic [15:0] d_in = 0;
  logic dtack_n, d_oe, ram_ras_n, ram_we_n, ram_ube_n, ram_lbe_n;
  logic [15:0] d_out, ram_wdata, ram_rdata;
  logic [7:0]  ram_addr;

  logic [15:0] mem [0:255];
  logic [15:0] ref_mem [0:255];
  int errors = 0, checks = 0;

  always #(PERIOD/2) clk = ~clk;

  early_ack_ram_ctrl uut (
    .clk, .rst_n, .as_n, .cs_n, .rw, .uds_n, .lds_n, .addr, .d_in,
    .dtack_n, .d_out, .d_oe, .ram_addr, .ram_ras_n, .ram_we_n,
    .ram_ube_n, .ram_lbe_n, .ram_wdata, .ram_rdata);

  assign ram_rdata = !ram_ras_n ? mem[ram_addr] : 16'hDEAD;

  always @(posedge clk) begin
    if (!ram_ras_n && !ram_we_n) begin
      if (!ram_ube_n) mem[ram_addr][15:8] <= ram_wdata[15:8];
      if (!ram_lbe_n) mem[ram_addr][7:0]  <= ram_wdata[7:0];
    end
  end

  function automatic logic [15:0] merge(logic [15:0] old, logic [15:0] nw, logic u, logic l);
    return {u ? old[15:8] : nw[15:8], l ? old[7:0] : nw[7:0]};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(dtack_n, 1, req);
    chk(ram_ras_n, 1, req);
    chk(ram_we_n, 1, req);
    chk(d_oe, 0, req);
  endtask

  task automatic run_cycle(input bit sel, input bit rd, input logic [7:0] a,
                           input logic [15:0] wd, input bit u, input bit l, input int rel);
    @(negedge clk);
    addr = a; rw = rd; d_in = wd; uds_n = u; lds_n = l; cs_n = !sel; as_n = 0;
    for (int k = 0; k < rel; k++) begin
      @(negedge clk);
      if (sel) begin
        chk(dtack_n, (k >= 3) ? 0 : 1, "R2");
        chk(ram_ras_n, (k >= 4) ? 0 : 1, "R3");
        chk(ram_we_n, (k >= 4 && !rd) ? 0 : 1, "R6");
        chk(d_oe, (k >= 6 && rd) ? 1 : 0, "R4");
        if (k >= 6 && rd) chk(d_out, ref_mem[a], "R4");
        if (k >= 4) begin
          chk(ram_addr, a, "R3");
          chk(ram_ube_n, u, "R6");
          chk(ram_lbe_n, l, "R6");
          if (!rd) chk(ram_wdata, wd, "R6");
        end
      end else begin
        chk(dtack_n, 1, "R7");
        chk(ram_ras_n, 1, "R7");
        chk(ram_we_n, 1, "R7");
      end
      if (k == rel - 1) as_n = 1;
    end
    if (rel == 0) as_n = 1;
    if (sel && !rd && rel >= 5) ref_mem[a] = merge(ref_mem[a], wd, u, l);
    @(negedge clk);
    if (rel < 10) chk_idle("R8"); else chk_idle("R5");
    cs_n = 1;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    int unused;
    unused = $urandom(32'd1234);
    for (int i = 0; i < 256; i++) begin
      mem[i] = 16'(i * 16'h0101 ^ 16'h5A3C);
      ref_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    chk_idle("R1");
    chk(ram_ube_n, 1, "R1");
    chk(ram_lbe_n, 1, "R1");
    rst_n = 1;
    @(negedge clk);
    chk_idle("R1");

    run_cycle(1, 1, 8'h10, 0, 0, 0, 10);
    run_cycle(1, 0, 8'h10, 16'hBEEF, 0, 0, 10);
    run_cycle(1, 1, 8'h10, 0, 0, 0, 10);
    run_cycle(1, 0, 8'h22, 16'h1234, 0, 1, 10);
    run_cycle(1, 0, 8'h22, 16'h9876, 1, 0, 10);
    run_cycle(1, 1, 8'h22, 0, 0, 0, 14);
    run_cycle(0, 1, 8'h22, 0, 0, 0, 10);
    run_cycle(0, 0, 8'h30, 16'hFFFF, 0, 0, 10);
    chk(mem[8'h30], ref_mem[8'h30], "R7");
    for (int r = 0; r < 10; r++) run_cycle(1, 1, 8'h40, 0, 0, 0, r);
    run_cycle(1, 0, 8'h41, 16'hA5A5, 0, 0, 3);
    chk(mem[8'h41], ref_mem[8'h41], "R8");
    run_cycle(1, 1, 8'h41, 0, 0, 0, 10);

    @(negedge clk);
    cs_n = 1; as_n = 0; rw = 1;
    @(negedge clk);
    cs_n = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(dtack_n, 1, "R9");
      chk(ram_ras_n, 1, "R9");
    end
    as_n = 1; cs_n = 1;
    @(negedge clk);
    chk_idle("R9");
    run_cycle(1, 1, 8'h22, 0, 0, 0, 10);

    for (int n = 0; n < 300; n++) begin
      bit sel, rd, u, l;
      logic [7:0] a;
      logic [15:0] wd;
      int rel;
      sel = ($urandom % 8) != 0;
      rd  = $urandom % 2;
      a   = 8'($urandom % 16);
      wd  = 16'($urandom);
      u   = $urandom % 2;
      l   = $urandom % 2;
      rel = 1 + $urandom % 13;
      run_cycle(sel, rd, a, wd, u, l, rel);
    end
    for (int i = 0; i < 16; i++) chk(mem[i], ref_mem[i], "R6");
    finish_run();
  end
endmodule